// File: doc/BRIEF.md
# Weak Ordering Synchronization Gate

This block sits on the path from a core's memory issue port to the memory system and decides, cycle by cycle, whether the operation at its input may pass. Each operation carries a two-bit class: ordinary data access, full synchronization, acquire or release. The gate keeps a count of data operations that have been issued but not yet completed. It also tracks whether a synchronization operation is in flight, and which class that operation is. From this state it applies a separate ordering rule for each class.

The operation and its payload flow through without storage. Both the input and the output side use valid/ready. An operation is taken from the core in a cycle where `in_valid` and `in_ready` are both high, and in that same cycle it appears on the output with `out_valid` high. `out_valid` only rises when the ordering rules allow the waiting operation to pass. `in_ready` is high only when the rules allow it and `out_ready` is also high, so back-pressure from memory reaches the core in the same cycle. `out_valid` does not depend on `out_ready`. Memory reports completions on two single-cycle pulse inputs, one for data operations and one for the synchronization operation.

Top module: `wo_sync_gate`

## Requirements
- R1: An operation is transferred exactly when `in_valid && in_ready`. Apart from the ordering rules, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`. `out_kind` and `out_payload` equal `in_kind` and `in_payload` in that cycle.
- R2: A data operation (`in_kind` = 0) is held while 15 data operations are outstanding, which is the limit of a 4-bit count. It may pass again in the cycle after a `data_done` pulse.
- R3: A data issue and a `data_done` pulse in the same cycle leave the outstanding count unchanged.
- R4: A full synchronization (`in_kind` = 1) is held until no data operation is outstanding.
- R5: While a full synchronization is in flight, data operations are held. They may pass from the cycle after `sync_done`.
- R6: An acquire (`in_kind` = 2) does not wait for outstanding data operations. While it is in flight, every later operation is held until `sync_done`.
- R7: A release (`in_kind` = 3) is held until no data operation is outstanding. While it is in flight, data operations may pass.
- R8: At most one synchronization operation is in flight. A second one of any class is held until `sync_done`, so synchronization operations pass in the order they were presented.
- R9: After reset nothing is outstanding, so any class of operation passes when `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core presents an operation |
| in_ready | output | 1 | Gate accepts the operation this cycle |
| in_kind | input | 2 | Class: 0 data, 1 full sync, 2 acquire, 3 release |
| in_payload | input | PAYLOAD_W | Opaque operation payload |
| out_valid | output | 1 | Operation forwarded to memory |
| out_ready | input | 1 | Memory can take an operation |
| out_kind | output | 2 | Forwarded class |
| out_payload | output | PAYLOAD_W | Forwarded payload |
| data_done | input | 1 | Pulse: one data operation completed |
| sync_done | input | 1 | Pulse: the in-flight sync operation completed |

## Verification
A wrong outstanding count shows up in one of two ways. A full synchronization or a release may pass while data is still in flight. Or the gate may stall early, before the fifteenth data issue, or late, after it. Either effect is seen at `in_ready` in the first cycle that the affected class is offered. A lost or stuck in-flight flag either lets an operation pass behind an acquire or a full barrier, or blocks all synchronization for good. A reference model in the bench tracks the count and the flag, and compares `in_ready`, `out_valid` and the forwarded fields against them in every cycle, so such a fault is reported in the cycle it first affects the handshake.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    OP_DATA = 2'd0,
    OP_FULL = 2'd1,
    OP_ACQ  = 2'd2,
    OP_REL  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/wo_inflight_ctr.sv
module wo_inflight_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             at_max,
  output logic             is_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic do_dec;
  assign do_dec  = dec && (count != '0);
  assign at_max  = (count == CNT_MAX);
  assign is_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && !do_dec) begin
      count <= count + 1'b1;
    end else if (do_dec && !inc) begin
      count <= count - 1'b1;
    end
  end

  // R2: the count never wraps
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |-> !inc);

  // R3: a simultaneous issue and completion leave the count unchanged
  a_r3_balanced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !is_zero) |=> (count == $past(count)));
endmodule

// File: rtl/wo_sync_track.sv
module wo_sync_track
  import wo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e start_kind,
  input  logic     done,
  output logic     busy,
  output op_kind_e busy_kind
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      busy_kind <= OP_DATA;
    end else if (start) begin
      busy      <= 1'b1;
      busy_kind <= start_kind;
    end else if (done) begin
      busy      <= 1'b0;
    end
  end

  // R8: a new sync operation never starts over one that is in flight
  a_r8_single_sync: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R8: the recorded class holds while the operation is in flight
  a_r8_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(busy_kind)));
endmodule

// File: rtl/wo_issue_policy.sv
module wo_issue_policy
  import wo_pkg::*;
(
  input  op_kind_e kind,
  input  logic     cnt_max,
  input  logic     cnt_zero,
  input  logic     sync_busy,
  input  op_kind_e sync_kind,
  output logic     allow
);
  logic data_blocked_by_sync;

  // A release in flight does not stop later data operations.
  assign data_blocked_by_sync = sync_busy && (sync_kind != OP_REL);

  always_comb begin
    unique case (kind)
      OP_DATA: allow = !cnt_max && !data_blocked_by_sync;
      OP_FULL: allow = !sync_busy && cnt_zero;
      OP_ACQ:  allow = !sync_busy;
      OP_REL:  allow = !sync_busy && cnt_zero;
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wo_sync_gate.sv
module wo_sync_gate
  import wo_pkg::*;
#(
  parameter int PAYLOAD_W = 32,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_kind,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic [PAYLOAD_W-1:0] out_payload,
  input  logic                 data_done,
  input  logic                 sync_done
);
  op_kind_e         kind;
  logic             allow;
  logic             fire;
  logic             cnt_max;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt;
  logic             sync_busy;
  op_kind_e         sync_kind;

  assign kind = op_kind_e'(in_kind);

  wo_issue_policy u_policy (
    .kind      (kind),
    .cnt_max   (cnt_max),
    .cnt_zero  (cnt_zero),
    .sync_busy (sync_busy),
    .sync_kind (sync_kind),
    .allow     (allow)
  );

  assign out_valid   = in_valid && allow;
  assign in_ready    = out_ready && allow;
  assign out_kind    = in_kind;
  assign out_payload = in_payload;
  assign fire        = in_valid && in_ready;

  wo_inflight_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (fire && (kind == OP_DATA)),
    .dec     (data_done),
    .count   (cnt),
    .at_max  (cnt_max),
    .is_zero (cnt_zero)
  );

  wo_sync_track u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fire && (kind != OP_DATA)),
    .start_kind (kind),
    .done       (sync_done),
    .busy       (sync_busy),
    .busy_kind  (sync_kind)
  );

  // R1: no acceptance without memory being ready
  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  // R4: a full barrier leaves only with no data in flight
  a_r4_full_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1) |-> (cnt == '0));

  // R7: a release leaves only with no data in flight
  a_r7_rel_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd3) |-> (cnt == '0));

  // R5, R6: nothing passes a full barrier or acquire except nothing
  a_r6_acq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_busy && (sync_kind == OP_ACQ || sync_kind == OP_FULL)) |-> !out_valid);
endmodule

// File: tb/wo_sync_gate_tb.sv
module wo_sync_gate_tb;
  localparam int PW = 16;
  localparam int MAXC = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_kind = 2'd0;
  logic [PW-1:0] in_payload = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1:0]    out_kind;
  logic [PW-1:0] out_payload;
  logic          data_done = 1'b0;
  logic          sync_done = 1'b0;

  always #4 clk = ~clk;

  wo_sync_gate #(.PAYLOAD_W(PW), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_payload(out_payload),
    .data_done(data_done), .sync_done(sync_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_cnt = 0;
  bit m_busy = 1'b0;
  logic [1:0] m_bkind = 2'd0;
  bit acc;

  function automatic bit exp_allow(logic [1:0] k);
    case (k)
      2'd0:    return (m_cnt < MAXC) && !(m_busy && m_bkind != 2'd3);
      2'd1:    return !m_busy && (m_cnt == 0);
      2'd2:    return !m_busy;
      default: return !m_busy && (m_cnt == 0);
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] k);
    case (k)
      2'd0:    return "R2/R5";
      2'd1:    return "R4";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // One cycle: drive, compare combinational handshake, update the model.
  task automatic cyc(bit v, logic [1:0] k, bit ordy, bit dd, bit sd);
    bit al;
    @(posedge clk); #1;
    in_valid = v; in_kind = k; in_payload = PW'($urandom);
    out_ready = ordy; data_done = dd; sync_done = sd;
    #2;
    al = exp_allow(k);
    chk(in_ready == (al && ordy), tag_of(k), in_ready, al && ordy);
    chk(out_valid == (v && al), "R1", out_valid, v && al);
    if (out_valid) begin
      chk(out_kind == k, "R1", out_kind, k);
      chk(out_payload == in_payload, "R1", out_payload, in_payload);
    end
    acc = v && ordy && al;
    m_cnt = m_cnt + ((acc && k == 2'd0) ? 1 : 0) - ((dd && m_cnt > 0) ? 1 : 0);
    if (sd) m_busy = 1'b0;
    if (acc && k != 2'd0) begin m_busy = 1'b1; m_bkind = k; end
  endtask

  task automatic drain();
    while (m_cnt > 0) cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    if (m_busy) cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0071));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state lets a full barrier pass
    cyc(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R9", acc, 1);
    cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);

    // R2: fill to the limit
    for (int i = 0; i < MAXC; i++) cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R2", acc, 0);
    cyc(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R4", acc, 0);
    cyc(1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    chk(acc == 1'b0, "R2", acc, 0);
    // R3: issue and completion together keep 14
    cyc(1'b1, 2'd0, 1'b1, 1'b1, 1'b0);
    chk(acc == 1'b1, "R3", acc, 1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R3", acc, 1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R3", acc, 0);
    drain();

    // R4/R5: full barrier then blocked data and sync
    cyc(1'b1, 2'd1, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R4", acc, 1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R5", acc, 0);
    cyc(1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R8", acc, 0);
    cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R5", acc, 1);

    // R6: acquire passes over outstanding data, then blocks
    cyc(1'b1, 2'd2, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R6", acc, 1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R6", acc, 0);
    cyc(1'b0, 2'd0, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R6", acc, 1);

    // R7: release waits for data, then lets data through
    cyc(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b0, "R7", acc, 0);
    while (m_cnt > 0) cyc(1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R7", acc, 1);
    cyc(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(acc == 1'b1, "R7", acc, 1);
    cyc(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
    chk(acc == 1'b0, "R8", acc, 0);
    drain();

    // R1: back-pressure from memory
    cyc(1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    chk(acc == 1'b0 && out_valid == 1'b1, "R1", out_valid, 1);

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] k;
      bit dd, sd;
      k  = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
      dd = (m_cnt > 0) && ($urandom % 3 == 0);
      sd = m_busy && ($urandom % 4 == 0);
      cyc(($urandom % 4) != 0, k, ($urandom % 5) != 0, dd, sd);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule